// File: doc/BRIEF.md
# FM Operator Envelope Level Shaper

This block sits between the envelope stepper of one FM operator and the operator itself. It does two jobs. First, it adjusts the envelope rate by keyboard position. When a key goes down it takes the upper bits of the voice pitch, clips that term to a fixed window, scales it by a 3-bit sensitivity and holds the result. It adds the held offset to the quantized base rate and clamps the sum to the rate range.

Second, on every sample it mixes in the LFO amplitude modulation. The envelope is a 12-bit attenuation, where all ones means the quietest output. The 8-bit LFO value is logarithmic. A 2-bit sensitivity selects a left shift of that value, and the shifted value is added to the envelope. Adding in the log domain makes the output quieter. The sum saturates at full attenuation.

Both results are registered together. A valid strobe follows each sample-enable pulse by one clock.

Top module: `env_level_shaper`

## Requirements
- R1: While reset is high, and up to the first sample strobe after it, `valid_o`, `rate_o` and `level_o` read 0.
- R2: `valid_o` is high in exactly the cycle after a cycle in which `sample_en_i` was high, and low in every other cycle.
- R3: The rate offset is floor((2·c·s + 7) / 14), where s is the 3-bit `rs_sens_i` (0..7) and c is the clipped pitch term. This is c·s/7 rounded half up. `rate_o` is min(`base_rate_i` + offset, 63).
- R4: c = (`pitch_i` >> 8) − 16, limited to 0..27. Pitch values whose upper bits are below 16 give c = 0. Values above 43 give c = 27.
- R5: The offset is captured only when `key_on_i` is high. Changes to `pitch_i` or `rs_sens_i` at other times leave `rate_o` unchanged on later samples. The new offset is in effect for samples issued three or more cycles after the key-on cycle.
- R6: When `am_sens_i` is 0, `level_o` equals `env_i` and `am_i` has no effect.
- R7: When `am_sens_i` is 1, 2 or 3, `level_o` is `env_i` + (`am_i` << `am_sens_i`).
- R8: The sum in R7 saturates at 4095 (0xFFF) and never wraps.
- R9: `rate_o` and `level_o` only change in cycles where `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_on_i | input | 1 | Key-on pulse; captures the rate offset |
| pitch_i | input | 14 | Voice pitch |
| rs_sens_i | input | 3 | Rate-scaling sensitivity, 0..7 |
| base_rate_i | input | 6 | Quantized envelope rate |
| sample_en_i | input | 1 | Sample enable |
| env_i | input | 12 | Envelope attenuation, 0xFFF quietest |
| am_i | input | 8 | Logarithmic LFO amplitude-modulation value |
| am_sens_i | input | 2 | Amp-mod sensitivity (shift amount) |
| rate_o | output | 6 | Scaled, clamped rate |
| level_o | output | 12 | Final attenuation |
| valid_o | output | 1 | Outputs updated in this cycle |

## Verification
The bench builds the block with its default parameters: a 14-bit pitch with an 8-bit shift, a bias of 16, a clip limit of 27, a 6-bit rate, a 12-bit level, an 8-bit amp-mod value and a 2-bit shift select. With these values the full clip window can be reached from pitch. That covers the low bound, interior points, the exact top at 43 and values beyond it. Every sensitivity value 0..7 is driven across the rounding points. The largest shift of 3 can push the 12-bit level exactly onto its saturation point and past it. The rate clamp at 63 can also be reached with a large offset.

// File: rtl/els_pkg.sv
package els_pkg;

  // Keyboard rate-scaling offset: c*s/max rounded half up, no divider in hardware.
  function automatic int rs_entry(input int c, input int s, input int smax);
    return (2 * c * s + smax) / (2 * smax);
  endfunction

  function automatic int clog2i(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

endpackage

// File: rtl/els_rs_rom.sv
module els_rs_rom #(
  parameter int CLIP_MAX = 27,
  parameter int SENS_W   = 3,
  parameter int ADDR_W   = 8,
  parameter int OFS_W    = 5
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [OFS_W-1:0]  data_o
);
  localparam int NSENS = 1 << SENS_W;
  localparam int SMAX  = NSENS - 1;
  localparam int DEPTH = (CLIP_MAX + 1) * NSENS;

  logic [OFS_W-1:0] mem [DEPTH];

  // Contents computed at elaboration; read is registered so it maps to block RAM.
  for (genvar a = 0; a < DEPTH; a++) begin : g_fill
    assign mem[a] = OFS_W'(els_pkg::rs_entry(a / NSENS, a % NSENS, SMAX));
  end

  always_ff @(posedge clk) begin
    data_o <= mem[addr_i];
  end
endmodule

// File: rtl/els_rate_unit.sv
module els_rate_unit #(
  parameter int PITCH_W  = 14,
  parameter int PSHIFT   = 8,
  parameter int PBIAS    = 16,
  parameter int CLIP_MAX = 27,
  parameter int SENS_W   = 3,
  parameter int RATE_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_on_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [SENS_W-1:0]  sens_i,
  input  logic [RATE_W-1:0]  base_rate_i,
  output logic [RATE_W-1:0]  rate_o,
  output logic [els_pkg::clog2i(CLIP_MAX+1)-1:0] ofs_o
);
  localparam int NSENS    = 1 << SENS_W;
  localparam int OFS_W    = els_pkg::clog2i(CLIP_MAX + 1);
  localparam int ADDR_W   = els_pkg::clog2i((CLIP_MAX + 1) * NSENS);
  localparam int SUM_W    = ((RATE_W > OFS_W) ? RATE_W : OFS_W) + 1;
  localparam int RATE_MAX = (1 << RATE_W) - 1;

  logic [PITCH_W-1:0] hi;
  logic [PITCH_W-1:0] clipped;
  logic [ADDR_W-1:0]  addr;
  logic [OFS_W-1:0]   rom_q;
  logic               kon_d;
  logic [OFS_W-1:0]   ofs_q;
  logic [SUM_W-1:0]   sum;

  always_comb begin
    hi = pitch_i >> PSHIFT;
    if (hi < PITCH_W'(PBIAS))
      clipped = '0;
    else if (hi - PITCH_W'(PBIAS) > PITCH_W'(CLIP_MAX))
      clipped = PITCH_W'(CLIP_MAX);
    else
      clipped = hi - PITCH_W'(PBIAS);
    addr = ADDR_W'(clipped * PITCH_W'(NSENS)) + ADDR_W'(sens_i);
  end

  els_rs_rom #(
    .CLIP_MAX(CLIP_MAX), .SENS_W(SENS_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
  ) u_rom (
    .clk(clk), .addr_i(addr), .data_o(rom_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kon_d <= 1'b0;
      ofs_q <= '0;
    end else begin
      kon_d <= key_on_i;
      if (kon_d) ofs_q <= rom_q;
    end
  end

  always_comb begin
    sum = SUM_W'(base_rate_i) + SUM_W'(ofs_q);
    rate_o = (sum > SUM_W'(RATE_MAX)) ? RATE_W'(RATE_MAX) : RATE_W'(sum);
  end

  assign ofs_o = ofs_q;
endmodule

// File: rtl/els_am_mix.sv
module els_am_mix #(
  parameter int LVL_W = 12,
  parameter int AM_W  = 8,
  parameter int AMS_W = 2
) (
  input  logic [LVL_W-1:0] env_i,
  input  logic [AM_W-1:0]  am_i,
  input  logic [AMS_W-1:0] ams_i,
  output logic [LVL_W-1:0] level_o
);
  localparam int SH_W    = AM_W + (1 << AMS_W) - 1;
  localparam int SUM_W   = ((LVL_W > SH_W) ? LVL_W : SH_W) + 1;
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  logic [SH_W-1:0]  shifted;
  logic [SUM_W-1:0] sum;

  always_comb begin
    shifted = SH_W'(am_i) << ams_i;
    if (ams_i == '0) shifted = '0;
    sum = SUM_W'(env_i) + SUM_W'(shifted);
    level_o = (sum > SUM_W'(LVL_MAX)) ? LVL_W'(LVL_MAX) : LVL_W'(sum);
  end
endmodule

// File: rtl/env_level_shaper.sv
module env_level_shaper #(
  parameter int PITCH_W  = 14,
  parameter int PSHIFT   = 8,
  parameter int PBIAS    = 16,
  parameter int CLIP_MAX = 27,
  parameter int SENS_W   = 3,
  parameter int RATE_W   = 6,
  parameter int LVL_W    = 12,
  parameter int AM_W     = 8,
  parameter int AMS_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_on_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [SENS_W-1:0]  rs_sens_i,
  input  logic [RATE_W-1:0]  base_rate_i,
  input  logic               sample_en_i,
  input  logic [LVL_W-1:0]   env_i,
  input  logic [AM_W-1:0]    am_i,
  input  logic [AMS_W-1:0]   am_sens_i,
  output logic [RATE_W-1:0]  rate_o,
  output logic [LVL_W-1:0]   level_o,
  output logic               valid_o
);
  localparam int OFS_W = els_pkg::clog2i(CLIP_MAX + 1);

  logic [RATE_W-1:0] rate_c;
  logic [LVL_W-1:0]  level_c;
  logic [OFS_W-1:0]  rs_ofs;

  els_rate_unit #(
    .PITCH_W(PITCH_W), .PSHIFT(PSHIFT), .PBIAS(PBIAS), .CLIP_MAX(CLIP_MAX),
    .SENS_W(SENS_W), .RATE_W(RATE_W)
  ) u_rate (
    .clk(clk), .rst(rst), .key_on_i(key_on_i), .pitch_i(pitch_i),
    .sens_i(rs_sens_i), .base_rate_i(base_rate_i), .rate_o(rate_c), .ofs_o(rs_ofs)
  );

  els_am_mix #(.LVL_W(LVL_W), .AM_W(AM_W), .AMS_W(AMS_W)) u_mix (
    .env_i(env_i), .am_i(am_i), .ams_i(am_sens_i), .level_o(level_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_o  <= '0;
      level_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= sample_en_i;
      if (sample_en_i) begin
        rate_o  <= rate_c;
        level_o <= level_c;
      end
    end
  end
endmodule

// File: rtl/env_level_shaper_chk.sv
module env_level_shaper_chk #(
  parameter int RATE_W = 6,
  parameter int LVL_W  = 12,
  parameter int AMS_W  = 2,
  parameter int OFS_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              key_on_i,
  input logic              sample_en_i,
  input logic [RATE_W-1:0] base_rate_i,
  input logic [LVL_W-1:0]  env_i,
  input logic [AMS_W-1:0]  am_sens_i,
  input logic [RATE_W-1:0] rate_o,
  input logic [LVL_W-1:0]  level_o,
  input logic              valid_o,
  input logic [OFS_W-1:0]  rs_ofs
);
  AST_VALID_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
    sample_en_i |=> valid_o); // R2
  AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(sample_en_i)); // R2
  AST_RATE_NOT_BELOW: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> rate_o >= $past(base_rate_i)); // R3
  AST_OFS_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(key_on_i, 2) |-> $stable(rs_ofs)); // R5
  AST_AMS_OFF: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(am_sens_i) == '0) |-> level_o == $past(env_i)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> level_o >= $past(env_i)); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(level_o) && $stable(rate_o))); // R9
endmodule

bind env_level_shaper env_level_shaper_chk #(
  .RATE_W(RATE_W), .LVL_W(LVL_W), .AMS_W(AMS_W), .OFS_W(OFS_W)
) u_chk (
  .clk(clk), .rst(rst), .key_on_i(key_on_i), .sample_en_i(sample_en_i),
  .base_rate_i(base_rate_i), .env_i(env_i), .am_sens_i(am_sens_i),
  .rate_o(rate_o), .level_o(level_o), .valid_o(valid_o), .rs_ofs(rs_ofs)
);

// File: tb/env_level_shaper_tb_top.sv
`timescale 1ns/1ps
module env_level_shaper_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key_on_i = 1'b0;
  logic [13:0] pitch_i = '0;
  logic [2:0]  rs_sens_i = '0;
  logic [5:0]  base_rate_i = '0;
  logic        sample_en_i = 1'b0;
  logic [11:0] env_i = '0;
  logic [7:0]  am_i = '0;
  logic [1:0]  am_sens_i = '0;
  logic [5:0]  rate_o;
  logic [11:0] level_o;
  logic        valid_o;

  always #2 clk = ~clk;

  env_level_shaper dut_i (
    .clk(clk), .rst(rst), .key_on_i(key_on_i), .pitch_i(pitch_i),
    .rs_sens_i(rs_sens_i), .base_rate_i(base_rate_i), .sample_en_i(sample_en_i),
    .env_i(env_i), .am_i(am_i), .am_sens_i(am_sens_i),
    .rate_o(rate_o), .level_o(level_o), .valid_o(valid_o)
  );

  typedef struct { int rate; int level; string req; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  int model_ofs = 0;
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ofs_model(input int pitch, input int sens);
    int c;
    c = (pitch >> 8) - 16;
    if (c < 0) c = 0;
    if (c > 27) c = 27;
    return (2 * c * sens + 7) / 14;
  endfunction

  task automatic press(input int pitch, input int sens);
    @(negedge clk);
    key_on_i = 1'b1; pitch_i = 14'(pitch); rs_sens_i = 3'(sens);
    model_ofs = ofs_model(pitch, sens);
    @(negedge clk);
    key_on_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Driver: pushes the expected item and pulses sample enable for one cycle.
  task automatic drive(input string req, input int base, input int env,
                       input int am, input int ams, input bit keep = 1'b0);
    exp_t e;
    int lv;
    int r;
    @(negedge clk);
    r = base + model_ofs; if (r > 63) r = 63;
    lv = env + ((ams == 0) ? 0 : (am << ams)); if (lv > 4095) lv = 4095;
    e.rate = r; e.level = lv; e.req = req;
    exp_q.push_back(e);
    base_rate_i = 6'(base); env_i = 12'(env); am_i = 8'(am);
    am_sens_i = 2'(ams); sample_en_i = 1'b1;
    if (!keep) begin
      @(negedge clk);
      sample_en_i = 1'b0;
    end
  endtask

  // Monitor: pops and compares whenever the strobe is seen.
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.req, " rate"}, int'(rate_o), e.rate);
        check({e.req, " level"}, int'(level_o), e.level);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int last_rate;
    int last_level;
    repeat (4) @(negedge clk);
    check("R1 valid in reset", int'(valid_o), 0);
    check("R1 rate in reset", int'(rate_o), 0);
    check("R1 level in reset", int'(level_o), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 level after reset", int'(level_o), 0);

    // R3 interior, R4 bounds, R3 clamp at 63
    press(30 << 8, 7);  drive("R3 mid", 10, 0, 0, 0);
    press(10 << 8, 7);  drive("R4 below window", 40, 0, 0, 0);
    press(16 << 8, 7);  drive("R4 at window start", 40, 0, 0, 0);
    press((43 << 8) + 255, 3); drive("R4 window top", 5, 0, 0, 0);
    press(60 << 8, 7);  drive("R3 clamp 63", 50, 0, 0, 0);
    for (int s = 0; s < 8; s++) begin
      press(20 << 8, s); drive("R3 sens sweep", 3, 0, 0, 0);
      press(39 << 8, s); drive("R3 sens sweep hi", 1, 0, 0, 0);
    end

    // R5: pitch and sensitivity change without key-on
    press(30 << 8, 7);
    @(negedge clk); pitch_i = 14'(60 << 8); rs_sens_i = 3'd0;
    repeat (3) @(negedge clk);
    drive("R5 held offset", 1, 0, 0, 0);

    // R6, R7, R8
    drive("R6 ams zero", 0, 100, 255, 0);
    drive("R7 ams 1", 0, 1000, 200, 1);
    drive("R7 ams 2", 0, 1000, 200, 2);
    drive("R7 ams 3", 0, 1000, 200, 3);
    drive("R8 saturate", 0, 4000, 255, 3);
    drive("R8 exact top", 0, 2055, 255, 3);
    drive("R8 full env", 0, 4095, 1, 1);

    // R2 back-to-back strobes
    drive("R2 burst a", 2, 10, 1, 1, 1'b1);
    drive("R2 burst b", 3, 20, 2, 2, 1'b1);
    drive("R2 burst c", 4, 30, 3, 3);
    repeat (2) @(negedge clk);
    check("R2 valid low when idle", int'(valid_o), 0);

    // R9: outputs hold without a strobe while inputs move
    last_rate = int'(rate_o); last_level = int'(level_o);
    base_rate_i = 6'd0; env_i = 12'd7; am_sens_i = 2'd0;
    repeat (4) @(negedge clk);
    check("R9 rate hold", int'(rate_o), last_rate);
    check("R9 level hold", int'(level_o), last_level);

    repeat (3) @(negedge clk);
    check("R2 all strobes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule